// File: doc/BRIEF.md
# Beam Spill Inhibit Generator

This block follows the beam spill. A one-cycle beam-start pulse opens a beam window, and the window stays open for a programmed number of 100 ns units. When that time runs out, the block raises an inhibit level. The inhibit then stays high until the next beam-start pulse. While the window is open, the block emits one-cycle sample strobes for histogramming. The first strobe comes a programmed offset after beam start, and further strobes follow at a programmed period. The block also routes two 8-bit groups of start-detector channels to the histogram logic. Each group is picked from overlapping banks by a 2-bit selector.

Time is counted in 100 ns units. A prescaler of `TICK_DIV` clock cycles makes one unit, and the default of 5 suits a 50 MHz clock. Each beam-start pulse captures the length, period and offset fields and restarts the prescaler. The timing of a window therefore depends only on the values present at its start.

Top module: `beam_inhibit_gen`

## Requirements
- R1: After reset, `inhibit` is 1 and `sample_stb` is 0 until the first beam-start pulse.
- R2: Let k be the clock edge that samples `beam_start` high with `cfg_len` = L > 0. Then `inhibit` is 0 in the cycles after edges k through k+L*TICK_DIV-1, and it is 1 from edge k+L*TICK_DIV onward.
- R3: Once `inhibit` is 1, it stays 1 until an edge samples `beam_start` high.
- R4: A beam-start pulse with `cfg_len` = 0 leaves `inhibit` at 1 and opens no window. No strobe follows it.
- R5: The first strobe is high for the one cycle after edge k+O*TICK_DIV, where O is `cfg_offset`. With O = 0 it is high in the cycle right after the beam-start edge.
- R6: Further strobes come after edges k+(O+j*P)*TICK_DIV, where P is `cfg_period` and j = 1, 2, and so on. A strobe only occurs while `inhibit` is 0. A strobe that would fall on the edge that closes the window is dropped.
- R7: `cfg_period` = 0 suppresses every strobe of that window, including the first.
- R8: A beam-start pulse during an open window restarts the length count, the prescaler and the strobe timing from that edge.
- R9: The length, period and offset are captured at beam start. Changes to these fields while a window is open have no effect on that window.
- R10: `hist_lo` is selected from `det_in` by `sel_lo`. Code 00 gives det_in[7:0], 01 gives det_in[11:4] and 10 gives det_in[15:8]. The lowest selected input appears on bit 0. The output is combinational.
- R11: `hist_hi` is selected from `det_in` by `sel_hi` in the same way. Code 00 gives det_in[23:16], 01 gives det_in[27:20] and 10 gives det_in[31:24].
- R12: Selector code 11 drives the corresponding output group to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_start | input | 1 | One-cycle pulse that opens or restarts the beam window |
| cfg_len | input | LEN_W | Window length in 100 ns units |
| cfg_period | input | PER_W | Strobe period in 100 ns units; 0 disables strobes |
| cfg_offset | input | OFS_W | Delay from beam start to first strobe in 100 ns units |
| det_in | input | 32 | Start-detector channels |
| sel_lo | input | 2 | Bank code for the lower 16 channels |
| sel_hi | input | 2 | Bank code for the upper 16 channels |
| inhibit | output | 1 | High outside the beam window |
| sample_stb | output | 1 | One-cycle histogram sample strobe |
| hist_lo | output | 8 | Selected group from the lower channels |
| hist_hi | output | 8 | Selected group from the upper channels |

## Verification
The assertions check five things on every cycle:
- a strobe never appears while inhibit is high;
- inhibit holds until a beam start arrives;
- a beam start with a nonzero length opens the window on the next cycle;
- a zero length keeps inhibit high;
- a zero period or a nonzero offset means no strobe on the cycle after beam start.

The exact cycle on which the window closes, the spacing of strobes, restarts inside a window, the capture of configuration at beam start and the bank selection can only be shown by the bench scenarios. The bench compares every cycle against a model that counts cycles since the last beam start.

// File: rtl/beam_inhibit_gen.sv
module beam_inhibit_gen #(
  parameter int TICK_DIV = 5,
  parameter int LEN_W    = 16,
  parameter int PER_W    = 12,
  parameter int OFS_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beam_start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [31:0]      det_in,
  input  logic [1:0]       sel_lo,
  input  logic [1:0]       sel_hi,
  output logic             inhibit,
  output logic             sample_stb,
  output logic [7:0]       hist_lo,
  output logic [7:0]       hist_hi
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SC_W  = (PER_W > OFS_W) ? PER_W : OFS_W;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             active;
  logic [PRE_W-1:0] pre;
  logic [LEN_W-1:0] ucnt;
  logic [LEN_W-1:0] len_q;
  logic [PER_W-1:0] per_q;
  logic [SC_W-1:0]  scnt;

  wire tick    = active && (pre == PRE_LAST);
  wire win_end = tick && (ucnt == len_q - 1'b1);
  wire sc_hit  = tick && (scnt == SC_W'(1));
  wire fire    = sc_hit && (per_q != '0) && !win_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      inhibit    <= 1'b1;
      sample_stb <= 1'b0;
      pre        <= '0;
      ucnt       <= '0;
      len_q      <= '0;
      per_q      <= '0;
      scnt       <= '0;
    end else if (beam_start) begin
      len_q   <= cfg_len;
      per_q   <= cfg_period;
      pre     <= '0;
      ucnt    <= '0;
      active  <= (cfg_len != '0);
      inhibit <= (cfg_len == '0);
      if (cfg_offset == '0) begin
        scnt       <= SC_W'(cfg_period);
        sample_stb <= (cfg_period != '0) && (cfg_len != '0);
      end else begin
        scnt       <= SC_W'(cfg_offset);
        sample_stb <= 1'b0;
      end
    end else begin
      sample_stb <= fire;
      if (tick) begin
        pre  <= '0;
        ucnt <= ucnt + 1'b1;
        if (win_end) begin
          active  <= 1'b0;
          inhibit <= 1'b1;
        end
        if (sc_hit)
          scnt <= SC_W'(per_q);
        else if (scnt != '0)
          scnt <= scnt - 1'b1;
      end else if (active) begin
        pre <= pre + 1'b1;
      end
    end
  end

  function automatic logic [7:0] pick(input logic [15:0] grp, input logic [1:0] s);
    case (s)
      2'b00:   pick = grp[7:0];
      2'b01:   pick = grp[11:4];
      2'b10:   pick = grp[15:8];
      default: pick = 8'h00;
    endcase
  endfunction

  assign hist_lo = pick(det_in[15:0],  sel_lo);
  assign hist_hi = pick(det_in[31:16], sel_hi);

endmodule

// File: rtl/beam_inhibit_chk.sv
module beam_inhibit_chk #(
  parameter int LEN_W = 16,
  parameter int PER_W = 12,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beam_start,
  input logic [LEN_W-1:0] cfg_len,
  input logic [PER_W-1:0] cfg_period,
  input logic [OFS_W-1:0] cfg_offset,
  input logic             inhibit,
  input logic             sample_stb
);

  assert_stb_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !inhibit);

  assert_window_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_start && cfg_len != '0) |=> !inhibit);

  assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_start && cfg_len == '0) |=> (inhibit && !sample_stb));

  assert_inhibit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !beam_start) |=> inhibit);

  assert_no_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_start && cfg_period == '0) |=> !sample_stb);

  assert_offset_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_start && cfg_offset != '0) |=> !sample_stb);

endmodule

bind beam_inhibit_gen beam_inhibit_chk #(
  .LEN_W(LEN_W), .PER_W(PER_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .beam_start(beam_start),
  .cfg_len(cfg_len), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
  .inhibit(inhibit), .sample_stb(sample_stb)
);

// File: tb/sim_beam_inhibit_gen.sv
module sim_beam_inhibit_gen;
  localparam int TD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beam_start = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [11:0] cfg_period = '0;
  logic [11:0] cfg_offset = '0;
  logic [31:0] det_in = '0;
  logic [1:0]  sel_lo = '0;
  logic [1:0]  sel_hi = '0;
  logic        inhibit, sample_stb;
  logic [7:0]  hist_lo, hist_hi;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  int since = 0;
  int L = 0, O = 0, P = 0;
  string scn = "R1";

  always #10 clk = ~clk;

  beam_inhibit_gen #(.TICK_DIV(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .beam_start(beam_start),
    .cfg_len(cfg_len), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
    .det_in(det_in), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .inhibit(inhibit), .sample_stb(sample_stb),
    .hist_lo(hist_lo), .hist_hi(hist_hi)
  );

  function automatic bit exp_inh();
    if (!started) return 1'b1;
    return !(since < L * TD);
  endfunction

  function automatic bit exp_stb();
    int u;
    if (!started || P == 0 || since >= L * TD || (since % TD) != 0) return 1'b0;
    u = since / TD;
    if (u < O) return 1'b0;
    return ((u - O) % P) == 0;
  endfunction

  function automatic logic [7:0] exp_bank(input logic [31:0] d, input int base, input logic [1:0] s);
    if (s == 2'b11) return 8'h00;
    return d[base + 4 * s +: 8];
  endfunction

  task automatic check_now();
    string t;
    logic [7:0] e;
    checks++;
    if (inhibit !== exp_inh()) begin
      fails++;
      t = !started ? "R1" : (L == 0 ? "R4" : (since >= L * TD ? "R3" : "R2"));
      $display("FAIL %s (scenario %s) inhibit actual=%0b expected=%0b t=%0d", t, scn, inhibit, exp_inh(), since);
    end
    checks++;
    if (sample_stb !== exp_stb()) begin
      fails++;
      t = !started ? "R1" : (P == 0 ? "R7" : ((since / TD) < O ? "R5" : "R6"));
      $display("FAIL %s (scenario %s) sample_stb actual=%0b expected=%0b t=%0d", t, scn, sample_stb, exp_stb(), since);
    end
    checks++;
    e = exp_bank(det_in, 0, sel_lo);
    if (hist_lo !== e) begin
      fails++;
      $display("FAIL %s hist_lo sel=%0d actual=%h expected=%h", sel_lo == 2'b11 ? "R12" : "R10", sel_lo, hist_lo, e);
    end
    checks++;
    e = exp_bank(det_in, 16, sel_hi);
    if (hist_hi !== e) begin
      fails++;
      $display("FAIL %s hist_hi sel=%0d actual=%h expected=%h", sel_hi == 2'b11 ? "R12" : "R11", sel_hi, hist_hi, e);
    end
  endtask

  task automatic step(input bit bs);
    beam_start = bs;
    @(posedge clk);
    if (beam_start) begin
      started = 1;
      since = 0;
      L = int'(cfg_len);
      O = int'(cfg_offset);
      P = int'(cfg_period);
    end else if (started && since < 1000000) begin
      since++;
    end
    @(negedge clk);
    beam_start = 1'b0;
    check_now();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic set_cfg(input int len, input int ofs, input int per);
    cfg_len = 16'(len);
    cfg_offset = 12'(ofs);
    cfg_period = 12'(per);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    scn = "R1";
    check_now();
    run(4);

    scn = "R2";
    set_cfg(3, 1, 1); step(1'b1); run(25);
    scn = "R5";
    set_cfg(8, 0, 2); step(1'b1); run(45);
    scn = "R4";
    set_cfg(0, 0, 1); step(1'b1); run(20);
    scn = "R7";
    set_cfg(6, 1, 0); step(1'b1); run(35);
    scn = "R6";
    set_cfg(4, 1, 3); step(1'b1); run(25);
    scn = "R8";
    set_cfg(4, 1, 1); step(1'b1); run(12); step(1'b1); run(30);
    scn = "R9";
    set_cfg(5, 2, 2); step(1'b1); run(3);
    set_cfg(1, 0, 1); run(30);

    scn = "R10";
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        sel_lo = 2'(a);
        sel_hi = 2'(b);
        det_in = $urandom;
        run(1);
      end
    end
    scn = "R12";
    sel_lo = 2'b11; sel_hi = 2'b11; det_in = 32'hFFFF_FFFF; run(1);
    scn = "R11";
    sel_hi = 2'b01; det_in = 32'h0AB0_0000; run(1);

    scn = "random";
    for (int it = 0; it < 1500; it++) begin
      set_cfg($urandom_range(0, 12), $urandom_range(0, 6), $urandom_range(0, 4));
      step(1'b1);
      for (int c = 0; c < int'($urandom_range(0, 60)); c++) begin
        det_in = $urandom;
        sel_lo = 2'($urandom);
        sel_hi = 2'($urandom);
        if ($urandom_range(0, 9) == 0) set_cfg($urandom_range(0, 12), $urandom_range(0, 6), $urandom_range(0, 4));
        step(1'b0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule